// File: doc/BRIEF.md
# Cross-Coupled Processor Sync Register

This block gives two processors one 32-bit control register each. Through these registers the two processors exchange a status byte and interrupt each other. The byte a processor writes into its outgoing field appears, read-only, in the incoming field of the other processor's register. Either processor can raise an interrupt for processor A or for processor B by writing a 1 to the trigger bit for that target. An interrupt reaches its target only if the target has set the enable bit in its own register.

Both registers accept byte-lane writes. A lane whose strobe is low keeps its contents, and none of its trigger bits fire. Reads are combinational and show the state left by the most recent clock edge. Each interrupt output is a registered one-cycle pulse. A trigger that finds its target disabled is dropped and is not held for later.

Top module: `xcpu_sync_reg`

## Requirements
- R1: After reset, every bit of both registers reads 0 and both interrupt outputs are low.
- R2: Bits 15:8 of each register are read/write and hold that side's outgoing byte. They are written when the write strobe and lane strobe 1 are both high.
- R3: Bits 7:0 of each register are read-only and return bits 15:8 of the other side's register. They follow a write on the other side from the next clock edge onward.
- R4: A lane whose strobe is low keeps its bits. With strobe 3 low, the enable bit does not change and no trigger fires. When the write strobe is low, the lane strobes and the data have no effect.
- R5: Bit 31 is read/write. It enables interrupts to the processor that owns the register.
- R6: Writing 1 to bit 29 (lane 3 strobed) from either side raises `irq_a` in the cycle after the write, if bit 31 of register A was 1 before that write.
- R7: Writing 1 to bit 30 (lane 3 strobed) from either side raises `irq_b` in the cycle after the write, if bit 31 of register B was 1 before that write.
- R8: A trigger whose target is disabled produces no pulse. Setting the enable bit later does not bring the trigger back.
- R9: Bits 29, 30 and 23:16 and 28:24 read as 0, and writes to them leave the read value at 0.
- R10: Each accepted trigger gives a pulse one cycle long. Triggers from both sides to the same target in the same cycle give a single pulse.

Ports are named with an `a_`/`b_` prefix for the side they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Write strobe, side A |
| a_be | input | 4 | Byte-lane strobes, side A |
| a_wdata | input | 32 | Write data, side A |
| a_rdata | output | 32 | Register read value, side A |
| b_wr_en | input | 1 | Write strobe, side B |
| b_be | input | 4 | Byte-lane strobes, side B |
| b_wdata | input | 32 | Write data, side B |
| b_rdata | output | 32 | Register read value, side B |
| irq_a | output | 1 | Interrupt pulse to processor A |
| irq_b | output | 1 | Interrupt pulse to processor B |

## Verification
A write is captured at the rising edge where the strobe is high. Both read ports, including the other side's incoming byte, show the result as soon as that edge has passed. The interrupt pulse for a trigger is high in the cycle right after that edge and gone one edge later. The bench drives every stimulus on a falling edge and checks read data and both interrupt lines on the next falling edge, one edge after capture. An idle step after each pulse checks that the line has dropped again.

// File: rtl/xsync_pkg.sv
package xsync_pkg;
   localparam int REG_W    = 32;
   localparam int LANE_W   = 8;
   localparam int LANES    = REG_W / LANE_W;
   localparam int NSIDE    = 2;
   localparam int IN_LSB   = 0;
   localparam int OUT_LSB  = 8;
   localparam int TRIG_LSB = 29;
   localparam int EN_BIT   = 31;
endpackage

// File: rtl/xsync_side.sv
module xsync_side
   import xsync_pkg::*;
#(
   parameter int RW    = REG_W,
   parameter int LW    = LANE_W,
   parameter int NTGT  = NSIDE,
   parameter int TLSB  = TRIG_LSB,
   parameter int EBIT  = EN_BIT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [RW/LW-1:0]    be,
   input  logic [RW-1:0]       wdata,
   input  logic [LW-1:0]       in_byte,
   output logic [LW-1:0]       out_byte,
   output logic                en,
   output logic [NTGT-1:0]     trig_req,
   output logic [RW-1:0]       rdata
);
   localparam int NL       = RW / LW;
   localparam int OUT_LANE = OUT_LSB / LW;
   localparam int EN_LANE  = EBIT / LW;
   localparam int TR_LANE  = TLSB / LW;

   if (RW % LW != 0) begin : g_bad_w
      $error("register width must be a multiple of the lane width");
   end
   if (TLSB + NTGT > EBIT) begin : g_bad_trig
      $error("trigger bits overlap the enable bit");
   end
   if (OUT_LSB + LW > TLSB) begin : g_bad_out
      $error("outgoing byte overlaps trigger bits");
   end

   logic [NL-1:0] lane_we;
   for (genvar i = 0; i < NL; i++) begin : g_lane
      assign lane_we[i] = wr_en & be[i];
   end

   logic [LW-1:0] out_q;
   logic          en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (lane_we[OUT_LANE]) out_q <= wdata[OUT_LSB +: LW];
         if (lane_we[EN_LANE])  en_q  <= wdata[EBIT];
      end
   end

   for (genvar t = 0; t < NTGT; t++) begin : g_trig
      assign trig_req[t] = lane_we[TR_LANE] & wdata[TLSB + t];
   end

   always_comb begin
      rdata                  = '0;
      rdata[IN_LSB +: LW]    = in_byte;
      rdata[OUT_LSB +: LW]   = out_q;
      rdata[EBIT]            = en_q;
   end

   assign out_byte = out_q;
   assign en       = en_q;
endmodule

// File: rtl/xsync_irq_gate.sv
module xsync_irq_gate #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   input  logic            en,
   output logic            irq
);
   if (NSRC < 1) begin : g_bad_src
      $error("at least one trigger source is required");
   end

   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (|req) & en;
   end
   assign irq = irq_q;
endmodule

// File: rtl/xcpu_sync_reg.sv
module xcpu_sync_reg
   import xsync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr_en,
   input  logic [LANES-1:0]  a_be,
   input  logic [REG_W-1:0]  a_wdata,
   output logic [REG_W-1:0]  a_rdata,
   input  logic              b_wr_en,
   input  logic [LANES-1:0]  b_be,
   input  logic [REG_W-1:0]  b_wdata,
   output logic [REG_W-1:0]  b_rdata,
   output logic              irq_a,
   output logic              irq_b
);
   logic [NSIDE-1:0]                 s_we;
   logic [NSIDE-1:0][LANES-1:0]      s_be;
   logic [NSIDE-1:0][REG_W-1:0]      s_wd;
   logic [NSIDE-1:0][REG_W-1:0]      s_rd;
   logic [NSIDE-1:0][LANE_W-1:0]     s_out;
   logic [NSIDE-1:0]                 s_en;
   logic [NSIDE-1:0][NSIDE-1:0]      s_trig;   // [source][target]
   logic [NSIDE-1:0][NSIDE-1:0]      t_req;    // [target][source]
   logic [NSIDE-1:0]                 t_irq;

   assign s_we = {b_wr_en, a_wr_en};
   assign s_be = {b_be, a_be};
   assign s_wd = {b_wdata, a_wdata};

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      xsync_side u_side (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (s_we[s]),
         .be       (s_be[s]),
         .wdata    (s_wd[s]),
         .in_byte  (s_out[NSIDE-1-s]),
         .out_byte (s_out[s]),
         .en       (s_en[s]),
         .trig_req (s_trig[s]),
         .rdata    (s_rd[s])
      );
   end

   for (genvar t = 0; t < NSIDE; t++) begin : g_tgt
      for (genvar s = 0; s < NSIDE; s++) begin : g_src
         assign t_req[t][s] = s_trig[s][t];
      end
      xsync_irq_gate #(.NSRC(NSIDE)) u_gate (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (t_req[t]),
         .en    (s_en[t]),
         .irq   (t_irq[t])
      );
   end

   assign a_rdata = s_rd[0];
   assign b_rdata = s_rd[1];
   assign irq_a   = t_irq[0];
   assign irq_b   = t_irq[1];
endmodule

// File: rtl/xsync_checker.sv
module xsync_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        a_wr_en,
   input logic [3:0]  a_be,
   input logic [31:0] a_wdata,
   input logic [31:0] a_rdata,
   input logic        b_wr_en,
   input logic [3:0]  b_be,
   input logic [31:0] b_wdata,
   input logic [31:0] b_rdata,
   input logic        irq_a,
   input logic        irq_b
);
   logic hit_a, hit_b;
   assign hit_a = (a_wr_en && a_be[3] && a_wdata[29]) || (b_wr_en && b_be[3] && b_wdata[29]);
   assign hit_b = (a_wr_en && a_be[3] && a_wdata[30]) || (b_wr_en && b_be[3] && b_wdata[30]);

   assert_irq_a_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> $past(hit_a && a_rdata[31]));
   assert_irq_a_deliver_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && a_rdata[31]) |=> irq_a);
   assert_irq_b_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> $past(hit_b && b_rdata[31]));
   assert_irq_b_deliver_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_b && b_rdata[31]) |=> irq_b);
   assert_drop_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_rdata[31]) |=> !irq_a);
   assert_drop_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_rdata[31]) |=> !irq_b);
   assert_zero_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rdata[30:16] == 15'd0) && (b_rdata[30:16] == 15'd0));
   assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_wr_en && a_be[1]) |=> $stable(a_rdata[15:8]));
   assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_wr_en && b_be[3]) |=> $stable(b_rdata[31]));
   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_a && !$past(hit_a)) |-> 1'b0);
endmodule

bind xcpu_sync_reg xsync_checker u_xsync_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_wr_en (a_wr_en),
   .a_be    (a_be),
   .a_wdata (a_wdata),
   .a_rdata (a_rdata),
   .b_wr_en (b_wr_en),
   .b_be    (b_be),
   .b_wdata (b_wdata),
   .b_rdata (b_rdata),
   .irq_a   (irq_a),
   .irq_b   (irq_b)
);

// File: tb/tb_xcpu_sync_reg.sv
module tb_xcpu_sync_reg;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        side;   // 0 = A, 1 = B
      logic        we;
      logic [3:0]  be;
      logic [31:0] d;
      logic [31:0] ea;
      logic [31:0] eb;
      logic        ia;
      logic        ib;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 4'b0010, 32'h0000_5A00, 32'h0000_5A00, 32'h0000_005A, 1'b0, 1'b0, 4'd2},  // R2 R3
      '{1'b1, 1'b1, 4'b0010, 32'h0000_C300, 32'h0000_5AC3, 32'h0000_C35A, 1'b0, 1'b0, 4'd3},  // R3
      '{1'b0, 1'b1, 4'b1101, 32'hFFFF_00FF, 32'h8000_5AC3, 32'h0000_C35A, 1'b0, 1'b0, 4'd8},  // R8 R5 R9
      '{1'b0, 1'b0, 4'b0000, 32'h0000_0000, 32'h8000_5AC3, 32'h0000_C35A, 1'b0, 1'b0, 4'd8},  // R8 no late pulse
      '{1'b1, 1'b1, 4'b1000, 32'h2000_0000, 32'h8000_5AC3, 32'h0000_C35A, 1'b1, 1'b0, 4'd6},  // R6
      '{1'b0, 1'b0, 4'b0000, 32'h0000_0000, 32'h8000_5AC3, 32'h0000_C35A, 1'b0, 1'b0, 4'd10}, // R10
      '{1'b0, 1'b1, 4'b1000, 32'hC000_0000, 32'h8000_5AC3, 32'h0000_C35A, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b1, 1'b1, 4'b1000, 32'h8000_0000, 32'h8000_5AC3, 32'h8000_C35A, 1'b0, 1'b0, 4'd5},  // R5
      '{1'b0, 1'b1, 4'b1000, 32'hE000_0000, 32'h8000_5AC3, 32'h8000_C35A, 1'b1, 1'b1, 4'd7},  // R7
      '{1'b0, 1'b1, 4'b1000, 32'hA000_0000, 32'h8000_5AC3, 32'h8000_C35A, 1'b1, 1'b0, 4'd10}, // R10
      '{1'b0, 1'b1, 4'b0111, 32'hFFFF_FFFF, 32'h8000_FFC3, 32'h8000_C3FF, 1'b0, 1'b0, 4'd4},  // R4 R9
      '{1'b0, 1'b1, 4'b1000, 32'h0000_0000, 32'h0000_FFC3, 32'h8000_C3FF, 1'b0, 1'b0, 4'd5},  // R5
      '{1'b1, 1'b1, 4'b1000, 32'hA000_0000, 32'h0000_FFC3, 32'h8000_C3FF, 1'b0, 1'b0, 4'd8},  // R8
      '{1'b0, 1'b0, 4'b1111, 32'hFFFF_FFFF, 32'h0000_FFC3, 32'h8000_C3FF, 1'b0, 1'b0, 4'd4}   // R4
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
   logic [3:0]  a_be = '0, b_be = '0;
   logic [31:0] a_wdata = '0, b_wdata = '0;
   logic [31:0] a_rdata, b_rdata;
   logic        irq_a, irq_b;
   int          n_chk = 0, n_fail = 0;
   logic        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xcpu_sync_reg dut (
      .clk(clk), .rst_n(rst_n),
      .a_wr_en(a_wr_en), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_wr_en(b_wr_en), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   task automatic check(input string tag, input logic [31:0] ea, input logic [31:0] eb,
                        input logic ia, input logic ib);
      n_chk++;
      if (a_rdata !== ea || b_rdata !== eb || irq_a !== ia || irq_b !== ib) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h irq=%b%b expected a=%h b=%h irq=%b%b",
                  tag, a_rdata, b_rdata, irq_a, irq_b, ea, eb, ia, ib);
      end
   endtask

   // drive at a falling edge, capture at the rising edge, observe at the next falling edge
   task automatic step(input logic awe, input logic [3:0] abe, input logic [31:0] ad,
                       input logic bwe, input logic [3:0] bbe, input logic [31:0] bd);
      a_wr_en = awe; a_be = abe; a_wdata = ad;
      b_wr_en = bwe; b_be = bbe; b_wdata = bd;
      @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 32'h0, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 32'h0, 32'h0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].side == 1'b0) step(VEC[i].we, VEC[i].be, VEC[i].d, 1'b0, 4'h0, 32'h0);
         else                     step(1'b0, 4'h0, 32'h0, VEC[i].we, VEC[i].be, VEC[i].d);
         check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].ea, VEC[i].eb, VEC[i].ia, VEC[i].ib);
      end

      // R5: enable A again
      step(1'b1, 4'b1000, 32'h8000_0000, 1'b0, 4'h0, 32'h0);
      check("R5 re-enable", 32'h8000_FFC3, 32'h8000_C3FF, 1'b0, 1'b0);
      // R10: both sides hit A in the same cycle -> one pulse
      step(1'b1, 4'b1000, 32'hA000_0000, 1'b1, 4'b1000, 32'hA000_0000);
      check("R10 joint trigger", 32'h8000_FFC3, 32'h8000_C3FF, 1'b1, 1'b0);
      step(1'b0, 4'h0, 32'h0, 1'b0, 4'h0, 32'h0);
      check("R10 pulse ends", 32'h8000_FFC3, 32'h8000_C3FF, 1'b0, 1'b0);
      // R6: trigger written together with a disable still sees the old enable
      step(1'b1, 4'b1000, 32'h2000_0000, 1'b0, 4'h0, 32'h0);
      check("R6 old enable used", 32'h0000_FFC3, 32'h8000_C3FF, 1'b1, 1'b0);
      // R1: reset in mid-run clears everything
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", 32'h0, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule